// File: doc/BRIEF.md
# Multi-Master Bus Arbiter

This block decides which of up to sixteen bus masters owns the address phase of a shared high-performance system bus. Each master has a request line and a lock line. The arbiter also watches the transfer type and burst type that the current owner drives, and the ready and response signals that come back from the addressed slave. From these it produces a one-hot grant vector, the index of the master that owns the address phase, and the index of the master whose transfer is in its data phase.

The default policy is round-robin rotation. The search starts at the master after the last winner. A run-time input switches to fixed priority, where the lowest index wins. Several conditions keep ownership with the current master: a fixed-length burst until its last beat is accepted, a locked sequence, and the single transfer that follows it. An undefined-length burst gives no such protection. A split response masks the data-phase master. The mask holds until a bit in any slave's release vector frees it. Retry and error responses cancel any hold, and the next rotation then starts after the master that took the response. When no unmasked master requests, master 0 gets the bus as the default master.

Top module: `mbus_arbiter`

## Requirements
- R1: `grant_o` always has exactly one bit set, and that bit is at position `owner_o`.
- R2: With `fixed_prio_i` low, a re-arbitration picks the first unmasked requester found by counting upward from the last winner + 1, modulo the master count. The winner becomes the new last winner.
- R3: With `fixed_prio_i` high, a re-arbitration picks the lowest-indexed unmasked requester.
- R4: When no unmasked master requests, a re-arbitration grants master 0 and leaves the last winner unchanged.
- R5: Owner, grant and data-phase owner change only at a rising edge where `ready_i` is high.
- R6: At every edge with `ready_i` high, `data_owner_o` takes the value that `owner_o` had before that edge.
- R7: Transfer codes are 0 idle, 1 busy, 2 non-sequential and 3 sequential. Burst codes 2–3 mean 4 beats, 4–5 mean 8 beats and 6–7 mean 16 beats. An accepted non-sequential transfer with such a code holds ownership. Accepted sequential beats count down the remaining beats. Busy cycles and stalled cycles do not count. Re-arbitration happens at the edge that accepts the last beat.
- R8: Burst codes 0 (single) and 1 (undefined length) hold nothing. The bus can move to another requester at the very next accepted beat.
- R9: While the owner's lock bit is high at accepted edges, ownership is held. Ownership is also held for one further accepted transfer after the lock bit drops.
- R10: Response codes are 0 okay, 1 error, 2 retry and 3 split. A split seen with `ready_i` high masks the data-phase master, and that master is already excluded at the same edge.
- R11: A set bit m in any slave's N_MST-bit slice of `split_rel_i` clears master m's mask at that edge. Master m can win from the following edge.
- R12: Retry or error seen with `ready_i` high cancels burst and lock holds. That edge's round-robin search then starts after `data_owner_o`.
- R13: Reset grants master 0, sets both owner outputs to 0, clears all masks and sets the last winner to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_i | input | N_MST | Request per master |
| lock_i | input | N_MST | Lock per master |
| trans_i | input | 2 | Transfer type of the address-phase owner |
| burst_i | input | 3 | Burst type of the address-phase owner |
| ready_i | input | 1 | Transfer accepted by the slave |
| resp_i | input | 2 | Slave response |
| split_rel_i | input | N_SLV*N_MST | Per-slave split-release vectors, slave s in bits s*N_MST upward |
| fixed_prio_i | input | 1 | 1 selects fixed priority, 0 round-robin |
| grant_o | output | N_MST | One-hot grant |
| owner_o | output | $clog2(N_MST) | Address-phase owner |
| data_owner_o | output | $clog2(N_MST) | Data-phase owner |

## Verification
A corrupted rotation pointer shows up at the next accepted edge where several masters request: the wrong index appears on `owner_o`. An off-by-one beat counter moves the handover one accepted beat early or late, so it shows on the edge that accepts the last beat. A stuck split mask has two possible symptoms. One is that a released master never wins and the default master keeps the grant. The other is that a split master wins on the edge where it should already be excluded. Each of these is visible within one or two cycles.

// File: rtl/mbus_arb_pkg.sv
`timescale 1ns/1ps
package mbus_arb_pkg;

    typedef enum logic [1:0] {
        TR_IDLE = 2'd0,
        TR_BUSY = 2'd1,
        TR_NSEQ = 2'd2,
        TR_SEQ  = 2'd3
    } trans_e;

    typedef enum logic [1:0] {
        RS_OKAY  = 2'd0,
        RS_ERROR = 2'd1,
        RS_RETRY = 2'd2,
        RS_SPLIT = 2'd3
    } resp_e;

    localparam int BEAT_W = 5;

    // beats that a burst code protects; single and undefined length protect one
    function automatic logic [BEAT_W-1:0] burst_beats(input logic [2:0] code);
        case (code)
            3'd2, 3'd3: burst_beats = 5'd4;
            3'd4, 3'd5: burst_beats = 5'd8;
            3'd6, 3'd7: burst_beats = 5'd16;
            default:    burst_beats = 5'd1;
        endcase
    endfunction

endpackage

// File: rtl/mbus_arb_pick.sv
`timescale 1ns/1ps
module mbus_arb_pick #(
    parameter int N_MST = 16
) (
    input  logic [N_MST-1:0]         elig_i,
    input  logic [$clog2(N_MST)-1:0] base_i,
    input  logic                     fixed_i,
    output logic                     found_o,
    output logic [$clog2(N_MST)-1:0] win_o
);
    localparam int IDW = $clog2(N_MST);

    always_comb begin
        found_o = 1'b0;
        win_o   = '0;
        for (int k = 0; k < N_MST; k++) begin
            int idx;
            idx = fixed_i ? k : (int'(base_i) + 1 + k) % N_MST;
            if (!found_o && elig_i[idx]) begin
                found_o = 1'b1;
                win_o   = IDW'(idx);
            end
        end
    end
endmodule

// File: rtl/mbus_arb_release.sv
`timescale 1ns/1ps
module mbus_arb_release #(
    parameter int N_MST = 16,
    parameter int N_SLV = 4
) (
    input  logic [N_SLV*N_MST-1:0] rel_i,
    output logic [N_MST-1:0]       any_o
);
    logic [N_MST-1:0] chain [N_SLV+1];

    assign chain[0] = '0;

    for (genvar s = 0; s < N_SLV; s++) begin : g_slv
        assign chain[s+1] = chain[s] | rel_i[s*N_MST +: N_MST];
    end

    assign any_o = chain[N_SLV];
endmodule

// File: rtl/mbus_arbiter.sv
`timescale 1ns/1ps
module mbus_arbiter
    import mbus_arb_pkg::*;
#(
    parameter int N_MST = 16,
    parameter int N_SLV = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_MST-1:0]         req_i,
    input  logic [N_MST-1:0]         lock_i,
    input  logic [1:0]               trans_i,
    input  logic [2:0]               burst_i,
    input  logic                     ready_i,
    input  logic [1:0]               resp_i,
    input  logic [N_SLV*N_MST-1:0]   split_rel_i,
    input  logic                     fixed_prio_i,
    output logic [N_MST-1:0]         grant_o,
    output logic [$clog2(N_MST)-1:0] owner_o,
    output logic [$clog2(N_MST)-1:0] data_owner_o
);
    localparam int IDW = $clog2(N_MST);

    typedef struct packed {
        logic [N_MST-1:0]  grant;
        logic [IDW-1:0]    owner;
        logic [IDW-1:0]    data_owner;
        logic [IDW-1:0]    ptr;
        logic [N_MST-1:0]  mask;
        logic [BEAT_W-1:0] beats;
        logic              tail;
    } arb_state_t;

    arb_state_t s_q, s_d;

    logic [N_MST-1:0]  rel_any;
    logic [N_MST-1:0]  split_hit;
    logic [N_MST-1:0]  elig;
    logic [IDW-1:0]    base;
    logic              found;
    logic [IDW-1:0]    win;
    logic              split_now;
    logic              abort_now;
    logic              hold;
    logic [BEAT_W-1:0] beats_nx;

    mbus_arb_release #(.N_MST(N_MST), .N_SLV(N_SLV)) rel_i (
        .rel_i (split_rel_i),
        .any_o (rel_any)
    );

    mbus_arb_pick #(.N_MST(N_MST)) pick_i (
        .elig_i  (elig),
        .base_i  (base),
        .fixed_i (fixed_prio_i),
        .found_o (found),
        .win_o   (win)
    );

    always_comb begin
        split_now = ready_i && (resp_i == RS_SPLIT);
        abort_now = ready_i && ((resp_i == RS_RETRY) || (resp_i == RS_ERROR));

        split_hit = '0;
        if (split_now) split_hit[s_q.data_owner] = 1'b1;

        elig = req_i & ~s_q.mask & ~split_hit;
        base = abort_now ? s_q.data_owner : s_q.ptr;

        // remaining protected beats after this edge
        if (split_now || abort_now)
            beats_nx = '0;
        else if (ready_i && trans_i == TR_NSEQ)
            beats_nx = burst_beats(burst_i) - 5'd1;
        else if (ready_i && trans_i == TR_SEQ && s_q.beats != '0)
            beats_nx = s_q.beats - 5'd1;
        else
            beats_nx = s_q.beats;

        hold = (beats_nx != '0)
            || (!(split_now || abort_now) && (lock_i[s_q.owner] || s_q.tail));

        s_d       = s_q;
        s_d.beats = beats_nx;
        s_d.mask  = (s_q.mask & ~rel_any) | split_hit;

        if (ready_i) begin
            s_d.data_owner = s_q.owner;
            s_d.tail       = !(split_now || abort_now) && lock_i[s_q.owner];
            if (!hold) begin
                s_d.owner = found ? win : '0;
                if (found) s_d.ptr = win;
            end
        end

        s_d.grant              = '0;
        s_d.grant[s_d.owner]   = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q            <= '0;
            s_q.grant[0]   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign grant_o      = s_q.grant;
    assign owner_o      = s_q.owner;
    assign data_owner_o = s_q.data_owner;
endmodule

// File: rtl/mbus_arbiter_chk.sv
`timescale 1ns/1ps
module mbus_arbiter_chk #(
    parameter int N_MST = 16,
    parameter int N_SLV = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [1:0]               trans_i,
    input logic [2:0]               burst_i,
    input logic                     ready_i,
    input logic [1:0]               resp_i,
    input logic [N_MST-1:0]         grant_o,
    input logic [$clog2(N_MST)-1:0] owner_o,
    input logic [$clog2(N_MST)-1:0] data_owner_o
);
    // R1
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(grant_o) == 1) && grant_o[owner_o]);

    // R5
    stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |=> $stable(owner_o) && $stable(grant_o) && $stable(data_owner_o));

    // R6
    data_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_i |=> data_owner_o == $past(owner_o));

    // R7
    burst_start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_i && trans_i == 2'd2 && burst_i[2:1] != 2'd0 && resp_i == 2'd0)
        |=> owner_o == $past(owner_o));
endmodule

bind mbus_arbiter mbus_arbiter_chk #(.N_MST(N_MST), .N_SLV(N_SLV)) chk_i (.*);

// File: tb/mbus_arbiter_tb_top.sv
`timescale 1ns/1ps
module mbus_arbiter_tb_top;
    localparam int NM  = 4;
    localparam int NS  = 2;
    localparam int IDW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NM-1:0]   req = '0;
    logic [NM-1:0]   lock = '0;
    logic [1:0]      trans = 2'd2;
    logic [2:0]      burst = 3'd0;
    logic            ready = 1'b1;
    logic [1:0]      resp = 2'd0;
    logic [NS*NM-1:0] rel = '0;
    logic            fixed = 1'b0;
    logic [NM-1:0]   grant;
    logic [IDW-1:0]  owner;
    logic [IDW-1:0]  downer;

    int n_chk = 0;
    int n_err = 0;
    int ptr = 0;

    always #5 clk = ~clk;

    mbus_arbiter #(.N_MST(NM), .N_SLV(NS)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .lock_i(lock),
        .trans_i(trans), .burst_i(burst), .ready_i(ready), .resp_i(resp),
        .split_rel_i(rel), .fixed_prio_i(fixed),
        .grant_o(grant), .owner_o(owner), .data_owner_o(downer)
    );

    task automatic expect_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one clock: inputs already driven; checks R1, R5, R6 on every edge
    task automatic tick();
        int prev_o, prev_d;
        logic was_rdy;
        prev_o  = owner;
        prev_d  = downer;
        was_rdy = ready;
        @(negedge clk);
        expect_eq("R1 grant", int'(grant), 1 << owner);
        if (was_rdy) expect_eq("R6 data owner", downer, prev_o);
        else begin
            expect_eq("R5 owner stall", owner, prev_o);
            expect_eq("R5 data stall", downer, prev_d);
        end
    endtask

    function automatic int rr_pick(input int p, input int last);
        for (int k = 0; k < NM; k++) begin
            int i;
            i = (last + 1 + k) % NM;
            if (p[i]) return i;
        end
        return -1;
    endfunction

    function automatic int lo_pick(input int p);
        for (int i = 0; i < NM; i++) if (p[i]) return i;
        return -1;
    endfunction

    task automatic seize(input int m);
        fixed = 1'b1; req = NM'(1 << m); tick();
        expect_eq("R3 seize", owner, m);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // R13 reset state
        expect_eq("R13 grant", int'(grant), 1);
        expect_eq("R13 owner", owner, 0);
        expect_eq("R13 data owner", downer, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R4 round-robin sweep over every request pattern, twice
        fixed = 1'b0; ptr = 0;
        for (int n = 0; n < 32; n++) begin
            int p, w;
            p = n % 16;
            req = NM'(p);
            tick();
            w = rr_pick(p, ptr);
            if (w < 0) expect_eq("R4 default", owner, 0);
            else begin expect_eq("R2 rotate", owner, w); ptr = w; end
        end

        // R3 / R4 fixed-priority sweep
        fixed = 1'b1;
        for (int p = 0; p < 16; p++) begin
            int w;
            req = NM'(p);
            tick();
            w = lo_pick(p);
            expect_eq(w < 0 ? "R4 default" : "R3 fixed", owner, w < 0 ? 0 : w);
        end

        // R5 stall: requests change while not ready
        req = 4'b0100; tick(); expect_eq("R3 fixed", owner, 2);
        ready = 1'b0; req = 4'b1000;
        for (int k = 0; k < 3; k++) begin tick(); expect_eq("R5 hold", owner, 2); end
        ready = 1'b1; tick(); expect_eq("R5 resume", owner, 3);

        // R7 every fixed burst code; busy and wait cycles do not count
        for (int b = 2; b < 8; b++) begin
            int len;
            len = (b < 4) ? 4 : (b < 6) ? 8 : 16;
            seize(1);
            fixed = 1'b0; req = 4'b0110;
            trans = 2'd2; burst = 3'(b); tick();
            expect_eq("R7 start", owner, 1);
            for (int k = 1; k < len; k++) begin
                if (k == 1) begin trans = 2'd1; tick(); expect_eq("R7 busy", owner, 1); end
                if (k == 2) begin ready = 1'b0; trans = 2'd3; tick(); expect_eq("R7 wait", owner, 1); ready = 1'b1; end
                trans = 2'd3; tick();
                expect_eq("R7 beat", owner, (k < len - 1) ? 1 : 2);
            end
            trans = 2'd2; burst = 3'd0;
        end

        // R8 undefined-length burst gives no hold
        seize(1);
        fixed = 1'b0; req = 4'b0110; burst = 3'd1; trans = 2'd2; tick();
        expect_eq("R8 handover", owner, 2);
        burst = 3'd0;

        // R9 lock plus one transfer
        fixed = 1'b1; req = 4'b0010; lock = 4'b0010; tick();
        expect_eq("R9 seize", owner, 1);
        fixed = 1'b0; req = 4'b0110;
        tick(); expect_eq("R9 locked", owner, 1);
        tick(); expect_eq("R9 locked", owner, 1);
        lock = '0;
        tick(); expect_eq("R9 tail", owner, 1);
        tick(); expect_eq("R9 release", owner, 2);

        // R10 / R11 split and release, no other requester
        seize(1); tick();
        expect_eq("R10 data owner", downer, 1);
        ready = 1'b0; resp = 2'd3; tick();
        ready = 1'b1; tick(); expect_eq("R10 masked", owner, 0);
        resp = 2'd0;
        tick(); expect_eq("R10 still masked", owner, 0);
        rel = 8'b0010_0000; tick(); expect_eq("R11 same edge", owner, 0);
        rel = '0; tick(); expect_eq("R11 freed", owner, 1);
        // R10 / R11 split with another requester, release via slave 0
        tick();
        req = 4'b0110; resp = 2'd3; tick(); expect_eq("R10 skip", owner, 2);
        resp = 2'd0; rel = 8'b0000_0010; tick(); expect_eq("R11 same edge", owner, 2);
        rel = '0; tick(); expect_eq("R11 freed", owner, 1);

        // R12 retry restarts rotation after the data-phase master
        seize(1); tick();
        fixed = 1'b0; req = 4'b1111; tick(); expect_eq("R2 rotate", owner, 2);
        ready = 1'b0; resp = 2'd2; tick();
        ready = 1'b1; tick(); expect_eq("R12 retry base", owner, 2);
        resp = 2'd0;
        // R12 error cuts a fixed burst short
        seize(1); tick();
        fixed = 1'b0; req = 4'b0110; trans = 2'd2; burst = 3'd3; tick();
        expect_eq("R7 start", owner, 1);
        trans = 2'd3; tick(); expect_eq("R7 beat", owner, 1);
        resp = 2'd1; tick(); expect_eq("R12 error ends burst", owner, 2);
        resp = 2'd0; trans = 2'd2; burst = 3'd0;

        // R13 reset mid-run restores pointer 0
        rst_n = 1'b0; @(negedge clk);
        expect_eq("R13 owner", owner, 0);
        expect_eq("R13 grant", int'(grant), 1);
        rst_n = 1'b1; req = 4'b1111; fixed = 1'b0; tick();
        expect_eq("R13 pointer", owner, 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule